// File: doc/BRIEF.md
# Initial Program Load Sequencer

This block brings a processor out of power-up by loading its first code from a byte-serial boot device. On a load request it streams a 24-byte header from the device into memory at addresses 0 to 23. The header is a boot status word (bytes 0 to 7) followed by two channel command words (bytes 8 to 15 and 16 to 23). The sequencer keeps a copy of both command words as they pass by. It then executes them as device-to-memory read transfers, which pull the next stage of boot code into memory.

When the last transfer byte has been stored, the sequencer reads the eight bytes at address 0 back from memory and assembles them into the initial status word. It presents that word to the processor with a one-cycle start strobe, with the problem-state bit cleared so that the processor begins in supervisor state. Every block that receives loaded code is tagged with protection key 0 through a key-write strobe.

Any malformed command, or a device that runs dry early, parks the sequencer in a sticky fault state and the processor is not started.

Top module: `ipl_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `fault_o`, `psw_load_o`, `dev_ready_o`, `mem_we_o`, `mem_re_o` and `key_we_o` are all 0.
- R2: A load request in the idle state makes the block accept exactly 24 device bytes and write them, in arrival order, to memory addresses 0 to 23.
- R3: A command word uses big-endian bit numbering (bit 0 is the most significant bit of its first byte). Its layout is: opcode in byte 0, start address in bytes 1 to 3, chain flag in bit 33 (value 0x40 in byte 4), and byte count in bytes 6 to 7, most significant byte first. For a valid command, the next `count` device bytes go to consecutive addresses starting at the start address.
- R4: The second command word runs only if the first has its chain flag set. The chain flag of the second word has no effect: no device byte beyond its count is taken.
- R5: Each accepted command produces exactly one `key_we_o` pulse, with `key_addr_o` equal to its start address (the block gets key 0). The pulse comes before any data byte of that transfer is taken.
- R6: After the final transfer byte, the block reads addresses 0 to 7 and drives `psw_o` with byte 0 as the most significant byte. Bit 15 (`psw_o[48]`) is forced to 0. `psw_load_o` pulses for exactly one cycle, once per boot.
- R7: A command whose opcode is not 0x02 (read), or whose count is 0, raises the fault and takes no data for that command.
- R8: If `dev_eos_i` is high while the block waits for a byte, and no byte is offered, the fault is raised. This applies to both the header and a transfer.
- R9: The fault is sticky until reset. While it is set, `psw_load_o` stays 0, load requests are ignored and `dev_ready_o` stays 0.
- R10: `dev_ready_o` is high only while the header or a transfer is in progress. Memory is never written and read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req_i | input | 1 | Start a boot (sampled while idle) |
| dev_valid_i | input | 1 | Device byte available |
| dev_data_i | input | 8 | Device byte |
| dev_eos_i | input | 1 | Device has no more data |
| dev_ready_o | output | 1 | Block accepts a device byte this cycle |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_re_o | output | 1 | Memory byte read enable (data one cycle later) |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after `mem_re_o` |
| key_we_o | output | 1 | Set the protection key of a loaded block to 0 |
| key_addr_o | output | 24 | Start address of the block whose key is set |
| psw_o | output | 64 | Initial status word for the processor |
| psw_load_o | output | 1 | One-cycle start strobe for the processor |
| busy_o | output | 1 | Boot in progress |
| fault_o | output | 1 | Sticky boot fault |

## Verification
The assertions assume that memory returns read data exactly one cycle after `mem_re_o`. They also assume a boot request only matters while the block is idle. The bench memory model is a single-cycle synchronous array, so the first assumption holds by construction. Requests are raised only between boots, or deliberately after a fault to show that they are ignored. The device model offers bytes only from its queue and raises end-of-stream only once the queue is empty, so `dev_valid_i` and `dev_eos_i` are never high together.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    localparam int unsigned AW      = 24;   // command-word address field width
    localparam int unsigned CW      = 16;   // command-word count field width
    localparam int unsigned OPW     = 8;    // opcode width
    localparam int unsigned WORD_W  = 64;   // status word and command word width
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned HDR_LEN = 24;   // header bytes read at boot
    localparam int unsigned PSW_LEN = WORD_W / BYTE_W;
    localparam int unsigned N_CCW   = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_CMD, S_XFER, S_PSWRD, S_PSWWAIT, S_GO, S_FAULT
    } state_e;

    typedef struct packed {
        logic [OPW-1:0] op;
        logic [AW-1:0]  addr;
        logic           chain;
        logic [CW-1:0]  cnt;
    } ccw_t;
endpackage

// File: rtl/ipl_ccw_decode.sv
module ipl_ccw_decode
    import ipl_pkg::*;
#(
    parameter int unsigned CHAIN_BIT = 33
) (
    input  logic [WORD_W-1:0] raw_i,
    output ccw_t              ccw_o
);
    // big-endian bit numbering: field bit n sits at raw_i[WORD_W-1-n]
    localparam int unsigned CHAIN_POS = WORD_W - 1 - CHAIN_BIT;

    always_comb begin
        ccw_o.op    = raw_i[WORD_W-1 -: OPW];
        ccw_o.addr  = raw_i[WORD_W-OPW-1 -: AW];
        ccw_o.chain = raw_i[CHAIN_POS];
        ccw_o.cnt   = raw_i[CW-1:0];
    end
endmodule

// File: rtl/ipl_psw_asm.sv
module ipl_psw_asm #(
    parameter int unsigned W         = 64,
    parameter int unsigned BW        = 8,
    parameter int unsigned CLEAR_BIT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          shift_i,
    input  logic [BW-1:0] byte_i,
    output logic [W-1:0]  word_o
);
    localparam int unsigned CLR_POS = W - 1 - CLEAR_BIT;
    localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << CLR_POS);

    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr_i)
            word_d = '0;
        else if (shift_i)
            word_d = {word_q[W-BW-1:0], byte_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q & KEEP_MASK;
endmodule

// File: rtl/ipl_seq.sv
module ipl_seq
    import ipl_pkg::*;
#(
    parameter logic [7:0] READ_OP = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req_i,
    input  logic              dev_valid_i,
    input  logic [7:0]        dev_data_i,
    input  logic              dev_eos_i,
    output logic              dev_ready_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [23:0]       mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              key_we_o,
    output logic [23:0]       key_addr_o,
    output logic [63:0]       psw_o,
    output logic              psw_load_o,
    output logic              busy_o,
    output logic              fault_o
);
    localparam int unsigned IDX_W    = $clog2(HDR_LEN);
    localparam int unsigned HBUF_W   = N_CCW * WORD_W;
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] CCW_BASE = IDX_W'(PSW_LEN);
    localparam logic [IDX_W-1:0] PSW_LAST = IDX_W'(PSW_LEN - 1);

    typedef struct packed {
        state_e             st;
        logic [IDX_W-1:0]   idx;
        logic [CW-1:0]      cnt;
        logic [AW-1:0]      addr;
        logic               sel;
        logic [HBUF_W-1:0]  hdr;
        logic               rdv;
    } seq_t;

    seq_t d, q;
    ccw_t ccw [N_CCW];
    ccw_t cur;
    logic psw_clr;

    // one decoder per command word held in the header buffer
    for (genvar g = 0; g < N_CCW; g++) begin : g_dec
        ipl_ccw_decode u_dec (
            .raw_i (q.hdr[(N_CCW-g)*WORD_W-1 -: WORD_W]),
            .ccw_o (ccw[g])
        );
    end

    ipl_psw_asm #(.W(WORD_W), .BW(BYTE_W), .CLEAR_BIT(15)) u_psw (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (psw_clr),
        .shift_i (q.rdv),
        .byte_i  (mem_rdata_i),
        .word_o  (psw_o)
    );

    always_comb begin
        d           = q;
        d.rdv       = 1'b0;
        cur         = q.sel ? ccw[1] : ccw[0];
        psw_clr     = 1'b0;
        dev_ready_o = 1'b0;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        key_we_o    = 1'b0;
        key_addr_o  = '0;
        psw_load_o  = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (load_req_i) begin
                    d.st    = S_HDR;
                    d.idx   = '0;
                    d.sel   = 1'b0;
                    psw_clr = 1'b1;
                end
            end
            S_HDR: begin
                dev_ready_o = 1'b1;
                if (dev_valid_i) begin
                    mem_we_o    = 1'b1;
                    mem_addr_o  = AW'(q.idx);
                    mem_wdata_o = dev_data_i;
                    if (q.idx >= CCW_BASE)
                        d.hdr = {q.hdr[HBUF_W-BYTE_W-1:0], dev_data_i};
                    if (q.idx == HDR_LAST) d.st  = S_CMD;
                    else                   d.idx = q.idx + 1'b1;
                end else if (dev_eos_i) begin
                    d.st = S_FAULT;
                end
            end
            S_CMD: begin
                if (cur.op != READ_OP || cur.cnt == '0) begin
                    d.st = S_FAULT;
                end else begin
                    key_we_o   = 1'b1;
                    key_addr_o = cur.addr;
                    d.addr     = cur.addr;
                    d.cnt      = cur.cnt;
                    d.st       = S_XFER;
                end
            end
            S_XFER: begin
                dev_ready_o = 1'b1;
                if (dev_valid_i) begin
                    mem_we_o    = 1'b1;
                    mem_addr_o  = q.addr;
                    mem_wdata_o = dev_data_i;
                    d.addr      = q.addr + 1'b1;
                    d.cnt       = q.cnt - 1'b1;
                    if (q.cnt == CW'(1)) begin
                        if (!q.sel && cur.chain) begin
                            d.sel = 1'b1;
                            d.st  = S_CMD;
                        end else begin
                            d.idx = '0;
                            d.st  = S_PSWRD;
                        end
                    end
                end else if (dev_eos_i) begin
                    d.st = S_FAULT;
                end
            end
            S_PSWRD: begin
                mem_re_o   = 1'b1;
                mem_addr_o = AW'(q.idx);
                d.rdv      = 1'b1;
                if (q.idx == PSW_LAST) d.st  = S_PSWWAIT;
                else                   d.idx = q.idx + 1'b1;
            end
            S_PSWWAIT: d.st = S_GO;
            S_GO: begin
                psw_load_o = 1'b1;
                d.st       = S_IDLE;
            end
            S_FAULT: d.st = S_FAULT;
            default: d.st = S_FAULT;
        endcase

        busy_o  = (q.st != S_IDLE) && (q.st != S_FAULT);
        fault_o = (q.st == S_FAULT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: '0, cnt: '0, addr: '0, sel: 1'b0,
                   hdr: '0, rdv: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ipl_seq_chk.sv
module ipl_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dev_ready_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic        key_we_o,
    input logic [63:0] psw_o,
    input logic        psw_load_o,
    input logic        busy_o,
    input logic        fault_o
);
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    assert_no_start_in_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!psw_load_o && !dev_ready_o));

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load_o |=> !psw_load_o);

    assert_supervisor_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load_o |-> !psw_o[48]);

    assert_key_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_we_o |-> (!mem_we_o && !dev_ready_o));

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!dev_ready_o && !mem_we_o && !mem_re_o && !key_we_o));

    assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));
endmodule

bind ipl_seq ipl_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_ready_o (dev_ready_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .key_we_o    (key_we_o),
    .psw_o       (psw_o),
    .psw_load_o  (psw_load_o),
    .busy_o      (busy_o),
    .fault_o     (fault_o)
);

// File: tb/ipl_seq_bench.sv
module ipl_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req_i = 1'b0;
    logic        dev_valid_i = 1'b0;
    logic [7:0]  dev_data_i = '0;
    logic        dev_eos_i = 1'b0;
    logic        dev_ready_o, mem_we_o, mem_re_o, key_we_o, psw_load_o, busy_o, fault_o;
    logic [23:0] mem_addr_o, key_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [63:0] psw_o;

    ipl_seq u_ipl_seq (
        .clk(clk), .rst_n(rst_n), .load_req_i(load_req_i),
        .dev_valid_i(dev_valid_i), .dev_data_i(dev_data_i), .dev_eos_i(dev_eos_i),
        .dev_ready_o(dev_ready_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .key_we_o(key_we_o), .key_addr_o(key_addr_o), .psw_o(psw_o),
        .psw_load_o(psw_load_o), .busy_o(busy_o), .fault_o(fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    logic [7:0]  dq[$];
    logic        eos_en = 1'b0, gap_en = 1'b0, fire = 1'b0, wipe = 1'b0;
    logic [7:0]  mem [0:4095];
    logic [7:0]  hexp [0:23];
    int          nload = 0, nkey = 0;
    logic [63:0] psw_cap = '0;
    logic [23:0] kaddr [0:3];

    // memory model: one-cycle synchronous read
    always @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'hEE;
        end else if (mem_we_o) begin
            mem[mem_addr_o[11:0]] <= mem_wdata_o;
        end
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[11:0]];
        fire <= dev_ready_o && dev_valid_i;
    end

    // device model and monitors, away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (fire && dq.size() > 0) void'(dq.pop_front());
        dev_valid_i = (dq.size() > 0) && !(gap_en && cyc[0]);
        dev_data_i  = (dq.size() > 0) ? dq[0] : 8'h00;
        dev_eos_i   = eos_en && (dq.size() == 0);
        if (psw_load_o) begin nload <= nload + 1; psw_cap <= psw_o; end
        if (key_we_o) begin
            if (nkey < 4) kaddr[nkey] <= key_addr_o;
            nkey <= nkey + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ccw(input logic [7:0] op, input logic [23:0] a,
                                           input logic ch, input logic [15:0] n);
        return {op, a, (ch ? 8'h40 : 8'h00), 8'h00, n};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; load_req_i = 1'b0; eos_en = 1'b0; gap_en = 1'b0;
        dq.delete();
        wipe = 1'b1;
        repeat (3) @(negedge clk);
        wipe = 1'b0; rst_n = 1'b1;
        nload = 0; nkey = 0;
        @(negedge clk); #1;
    endtask

    task automatic push_hdr(input logic [63:0] psw, input logic [63:0] c0, input logic [63:0] c1);
        logic [191:0] h;
        h = {psw, c0, c1};
        for (int i = 0; i < 24; i++) begin
            hexp[i] = h[191 - 8*i -: 8];
            dq.push_back(hexp[i]);
        end
    endtask

    task automatic boot_and_wait();
        @(negedge clk); #1; load_req_i = 1'b1;
        @(negedge clk); #1; load_req_i = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (psw_load_o || fault_o) break;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    function automatic int hdr_mismatch();
        int m = 0;
        for (int i = 0; i < 24; i++) if (mem[i] !== hexp[i]) m++;
        return m;
    endfunction

    task automatic t_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 fault", fault_o, 0);
        chk("R1 quiet", {psw_load_o, dev_ready_o, mem_we_o, mem_re_o, key_we_o}, 0);
    endtask

    task automatic t_single();
        do_reset();
        push_hdr(64'h0123_4567_89AB_CDEF, mk_ccw(8'h02, 24'h000100, 1'b0, 16'd5),
                 mk_ccw(8'h02, 24'h000300, 1'b0, 16'd2));
        for (int i = 0; i < 5; i++) dq.push_back(8'hA0 + 8'(i));
        dq.push_back(8'h55); dq.push_back(8'h66);
        boot_and_wait();
        chk("R2 header image", hdr_mismatch(), 0);
        for (int i = 0; i < 5; i++) chk("R3 payload", mem[12'h100 + i], 8'hA0 + 8'(i));
        chk("R3 no overrun", mem[12'h105], 8'hEE);
        chk("R4 second word not run", mem[12'h300], 8'hEE);
        chk("R4 leftover bytes", dq.size(), 2);
        chk("R5 key count", nkey, 1);
        chk("R5 key addr", kaddr[0], 24'h000100);
        chk("R6 start count", nload, 1);
        chk("R6 status word", psw_cap, 64'h0122_4567_89AB_CDEF);
        chk("R6 fault clear", fault_o, 0);
        chk("R10 ready low after boot", dev_ready_o, 0);
    endtask

    task automatic t_chain();
        do_reset();
        gap_en = 1'b1;
        push_hdr(64'hFEDC_BA98_7654_3210, mk_ccw(8'h02, 24'h000200, 1'b1, 16'd3),
                 mk_ccw(8'h02, 24'h000300, 1'b1, 16'd4));
        for (int i = 0; i < 7; i++) dq.push_back(8'h10 + 8'(i));
        for (int i = 0; i < 3; i++) dq.push_back(8'h77);
        boot_and_wait();
        chk("R2 header image chained", hdr_mismatch(), 0);
        for (int i = 0; i < 3; i++) chk("R4 first block", mem[12'h200 + i], 8'h10 + 8'(i));
        for (int i = 0; i < 4; i++) chk("R4 second block", mem[12'h300 + i], 8'h13 + 8'(i));
        chk("R4 second chain ignored", dq.size(), 3);
        chk("R5 two keys", nkey, 2);
        chk("R5 key addr 0", kaddr[0], 24'h000200);
        chk("R5 key addr 1", kaddr[1], 24'h000300);
        chk("R6 status word chained", psw_cap, 64'hFEDC_BA98_7654_3210);
        chk("R6 one start", nload, 1);
    endtask

    task automatic t_zero_count();
        do_reset();
        push_hdr(64'h1, mk_ccw(8'h02, 24'h000400, 1'b0, 16'd0), 64'h0);
        dq.push_back(8'h99);
        boot_and_wait();
        chk("R7 zero count fault", fault_o, 1);
        chk("R7 no key", nkey, 0);
        chk("R7 no data taken", dq.size(), 1);
        chk("R9 no start", nload, 0);
        @(negedge clk); #1; load_req_i = 1'b1;
        @(negedge clk); #1; load_req_i = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk("R9 request ignored", {busy_o, dev_ready_o, fault_o}, 3'b001);
        chk("R9 still no data", dq.size(), 1);
    endtask

    task automatic t_bad_op();
        do_reset();
        push_hdr(64'h1, mk_ccw(8'h01, 24'h000400, 1'b0, 16'd2), 64'h0);
        dq.push_back(8'h31); dq.push_back(8'h32);
        boot_and_wait();
        chk("R7 bad opcode fault", fault_o, 1);
        chk("R7 bad opcode no write", mem[12'h400], 8'hEE);
        chk("R9 bad opcode no start", nload, 0);
    endtask

    task automatic t_eos_hdr();
        do_reset();
        for (int i = 0; i < 10; i++) dq.push_back(8'h40 + 8'(i));
        eos_en = 1'b1;
        boot_and_wait();
        chk("R8 header eos fault", fault_o, 1);
        chk("R8 partial header kept", mem[9], 8'h49);
        chk("R8 nothing past eos", mem[10], 8'hEE);
        chk("R9 header eos no start", nload, 0);
    endtask

    task automatic t_eos_xfer();
        do_reset();
        push_hdr(64'h1, mk_ccw(8'h02, 24'h000500, 1'b0, 16'd6), 64'h0);
        for (int i = 0; i < 3; i++) dq.push_back(8'hC0 + 8'(i));
        eos_en = 1'b1;
        boot_and_wait();
        chk("R8 transfer eos fault", fault_o, 1);
        chk("R8 partial data", mem[12'h502], 8'hC2);
        chk("R5 key before short data", nkey, 1);
        chk("R9 transfer eos no start", nload, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_single();
        t_chain();
        t_zero_count();
        t_bad_op();
        t_eos_hdr();
        t_eos_xfer();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule